// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

This block turns 24-bit stereo samples into a three-wire serial audio stream made of a bit clock, a word clock and a data line. A 3-bit mode input picks one of eight layouts. There are four right-justified widths (16, 18, 20 and 24 bit), 24-bit left-justified, and 24-bit I2S, each with the block as clock master. Left-justified and I2S are also available with the block as clock slave. In the master modes the block divides its own clock down to a bit clock of 64 periods per sample, giving 32 per channel slot. In the slave modes it follows externally supplied bit and word clocks, and the bit clock may run anywhere from 64 to 128 periods per sample.

Each sample arrives with one status flag per channel. A flagged channel keeps its last good value, and that value is re-sent until a clean sample replaces it. While the receive path reports loss of lock, the data line carries only zeros. A channel's sample is latched at the start of its slot, so a new sample that arrives mid-slot cannot corrupt the word being sent.

Top module: `pcm_serial_formatter`

## Requirements
- R1: In modes 0, 1, 2 and 3, counting slot positions from 0 at the first bit after a word-clock edge, positions 32-W to 31 carry sample bits 23 down to 24-W (W = 16, 18, 20, 24), MSB first. All earlier positions are zero.
- R2: In modes 4 and 6, positions 0 to 23 carry sample bits 23 down to 0, and positions 24 to 31 are zero.
- R3: In modes 5 and 7, position 0 is zero, positions 1 to 24 carry sample bits 23 down to 0, and positions 25 to 31 are zero.
- R4: In modes 0 to 5, `bclk_out` has a period of 2*BCLK_HALF clock cycles and a frame spans 64 bit-clock periods. `sdata_out` and `wclk_out` change only in the cycle where `bclk_out` falls.
- R5: The word clock is high during the left slot in modes 0, 1, 2, 3, 4 and 6, and low during the left slot in modes 5 and 7.
- R6: In modes 6 and 7, `bclk_out` and `wclk_out` stay 0. Slots are timed from `bclk_in` and `wclk_in`, and the data changes after falling edges of `bclk_in`.
- R7: In slave modes, every `wclk_in` edge restarts the slot at position 0. Positions from 32 up to the next word-clock edge are zero, which allows up to 64 bit-clock periods per slot.
- R8: A sample strobed with `err_left` (or `err_right`) set leaves that channel's last error-free value in place. That value is re-sent until a sample strobes in without the flag.
- R9: While `unlock` is 1, `sdata_out` is 0 in every bit slot.
- R10: A channel's sample is captured at its slot's position 0. A sample strobed mid-slot first appears in the next slot of its channel.
- R11: After reset, `sdata_out`, `bclk_out` and `wclk_out` are 0, and both channels send zero until a sample is strobed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Format select 0..7 |
| smp_valid | input | 1 | One-cycle strobe for a new stereo sample |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| err_left | input | 1 | Left sub-frame had a bit-level error |
| err_right | input | 1 | Right sub-frame had a bit-level error |
| unlock | input | 1 | Receiver not locked; mute data |
| bclk_in | input | 1 | External bit clock (slave modes) |
| wclk_in | input | 1 | External word clock (slave modes) |
| bclk_out | output | 1 | Generated bit clock (master modes) |
| wclk_out | output | 1 | Generated word clock (master modes) |
| sdata_out | output | 1 | Serial audio data |

## Verification
The hardest situation to reach is a sample arriving in the middle of a slot that is already being sent, together with the slave case where the bit clock runs well above 64 periods per sample. For the first case, the bench drives a second strobe from inside its capture loop at a known bit position of the left slot. It then expects the old left word and the new right word. For the second case, the bench produces its own bit and word clocks with 64 bit periods per slot. It checks the payload and also that every position past 31 is zero.

// File: rtl/sai_fmt_pkg.sv
package sai_fmt_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int SLOT_BITS = 32;
    localparam int IDX_W     = $clog2(2 * SLOT_BITS);
    localparam int IDX_MAX   = 2 * SLOT_BITS - 1;
    localparam int SEL_W     = $clog2(SAMPLE_W);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [IDX_W-1:0]    slot_idx_t;

    typedef enum logic [1:0] {
        JUST_RIGHT = 2'd0,
        JUST_LEFT  = 2'd1,
        JUST_I2S   = 2'd2
    } just_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        just_e      just;
        logic [5:0] width;
        logic       left_high;
        logic       slave;
    } fmt_t;

    function automatic fmt_t decode_mode(input logic [2:0] m);
        fmt_t f;
        f.just      = JUST_RIGHT;
        f.width     = 6'(SAMPLE_W);
        f.left_high = 1'b1;
        f.slave     = 1'b0;
        case (m)
            3'd0: f.width = 6'd16;
            3'd1: f.width = 6'd18;
            3'd2: f.width = 6'd20;
            3'd3: f.width = 6'(SAMPLE_W);
            3'd4: f.just  = JUST_LEFT;
            3'd5: begin
                f.just      = JUST_I2S;
                f.left_high = 1'b0;
            end
            3'd6: begin
                f.just  = JUST_LEFT;
                f.slave = 1'b1;
            end
            default: begin
                f.just      = JUST_I2S;
                f.left_high = 1'b0;
                f.slave     = 1'b1;
            end
        endcase
        return f;
    endfunction

    // Bit carried at a slot position for a given format; zero outside the payload.
    function automatic logic slot_bit(input fmt_t f, input sample_t s, input slot_idx_t idx);
        int   p;
        int   first;
        int   off;
        logic b;
        b = 1'b0;
        p = int'(idx);
        case (f.just)
            JUST_LEFT: first = 0;
            JUST_I2S:  first = 1;
            default:   first = SLOT_BITS - int'(f.width);
        endcase
        off = p - first;
        if (p < SLOT_BITS && off >= 0 && off < int'(f.width))
            b = s[SEL_W'(SAMPLE_W - 1 - off)];
        return b;
    endfunction

endpackage

// File: rtl/sai_sample_hold.sv
module sai_sample_hold
    import sai_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  sample_t    in_smp [2],
    input  logic [1:0] in_err,
    output sample_t    held   [2]
);

    for (genvar c = 0; c < 2; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                held[c] <= '0;
            else if (valid && !in_err[c])
                held[c] <= in_smp[c];
        end

        AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (rst)
            (valid && in_err[c]) |=> (held[c] == $past(held[c]))); // R8
        AST_TAKE_CLEAN: assert property (@(posedge clk) disable iff (rst)
            (valid && !in_err[c]) |=> (held[c] == $past(in_smp[c]))); // R8
    end

endmodule

// File: rtl/sai_master_clk.sv
module sai_master_clk #(
    parameter int BCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic bclk,
    output logic tick
);

    localparam int DIV_W = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BCLK_HALF - 1);

    logic [DIV_W-1:0] div_q;
    logic             wrap;

    assign wrap = (div_q == DIV_LAST);
    assign tick = en && wrap && bclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
            bclk  <= 1'b0;
        end else begin
            div_q <= wrap ? '0 : div_q + 1'b1;
            if (wrap)
                bclk <= ~bclk;
        end
    end

    AST_TICK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        tick |=> !bclk); // R4

endmodule

// File: rtl/sai_slave_track.sv
module sai_slave_track #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic left_high,
    input  logic bclk_in,
    input  logic wclk_in,
    output logic tick,
    output logic wedge,
    output logic at_left
);

    logic [SYNC_STAGES-1:0] b_sync;
    logic [SYNC_STAGES-1:0] w_sync;
    logic                   b_prev;
    logic                   w_last;
    logic                   b_now;
    logic                   w_now;

    assign b_now   = b_sync[SYNC_STAGES-1];
    assign w_now   = w_sync[SYNC_STAGES-1];
    assign tick    = en && b_prev && !b_now;
    assign wedge   = tick && (w_now != w_last);
    assign at_left = (w_now == left_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            b_sync <= '0;
            w_sync <= '0;
            b_prev <= 1'b0;
            w_last <= 1'b0;
        end else begin
            b_sync <= {b_sync[SYNC_STAGES-2:0], bclk_in};
            w_sync <= {w_sync[SYNC_STAGES-2:0], wclk_in};
            b_prev <= b_now;
            if (tick)
                w_last <= w_now;
        end
    end

endmodule

// File: rtl/sai_slot_seq.sv
module sai_slot_seq
    import sai_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      slave,
    input  logic      m_tick,
    input  logic      s_tick,
    input  logic      s_wedge,
    input  logic      s_left,
    output logic      tick,
    output chan_e     chan_nx,
    output slot_idx_t idx_nx
);

    localparam slot_idx_t LAST_SLOT = slot_idx_t'(SLOT_BITS - 1);
    localparam slot_idx_t SAT_IDX   = slot_idx_t'(IDX_MAX);

    chan_e     chan_q;
    slot_idx_t idx_q;

    assign tick = slave ? s_tick : m_tick;

    always_comb begin
        chan_nx = chan_q;
        idx_nx  = idx_q;
        if (slave) begin
            if (s_wedge) begin
                idx_nx  = '0;
                chan_nx = s_left ? CH_LEFT : CH_RIGHT;
            end else if (idx_q != SAT_IDX) begin
                idx_nx = idx_q + 1'b1;
            end
        end else begin
            if (idx_q >= LAST_SLOT) begin
                idx_nx  = '0;
                chan_nx = (chan_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
            end else begin
                idx_nx = idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= CH_RIGHT;
            idx_q  <= SAT_IDX;
        end else if (tick) begin
            chan_q <= chan_nx;
            idx_q  <= idx_nx;
        end
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tick && !slave) |=> (idx_q <= LAST_SLOT)); // R4
    AST_WEDGE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (slave && s_wedge) |=> (idx_q == '0)); // R7

endmodule

// File: rtl/sai_bit_shifter.sv
module sai_bit_shifter
    import sai_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fmt_t      fmt,
    input  logic      tick,
    input  chan_e     chan_nx,
    input  slot_idx_t idx_nx,
    input  sample_t   held [2],
    input  logic      unlock,
    output logic      sdata,
    output logic      wclk
);

    sample_t cur_q;
    sample_t src;
    logic    slot_start;

    assign slot_start = (idx_nx == '0);
    assign src = slot_start ? held[chan_nx] : cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            sdata <= 1'b0;
            wclk  <= 1'b0;
        end else if (tick) begin
            if (slot_start)
                cur_q <= src;
            sdata <= unlock ? 1'b0 : slot_bit(fmt, src, idx_nx);
            wclk  <= (chan_nx == CH_LEFT) ? fmt.left_high : ~fmt.left_high;
        end
    end

    AST_UNLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && unlock) |=> !sdata); // R9
    AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sdata)); // R4

endmodule

// File: rtl/pcm_serial_formatter.sv
module pcm_serial_formatter
    import sai_fmt_pkg::*;
#(
    parameter int BCLK_HALF   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          mode,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                err_left,
    input  logic                err_right,
    input  logic                unlock,
    input  logic                bclk_in,
    input  logic                wclk_in,
    output logic                bclk_out,
    output logic                wclk_out,
    output logic                sdata_out
);

    fmt_t      fmt;
    sample_t   in_smp [2];
    sample_t   held   [2];
    logic      m_bclk;
    logic      m_tick;
    logic      s_tick;
    logic      s_wedge;
    logic      s_left;
    logic      tick;
    chan_e     chan_nx;
    slot_idx_t idx_nx;
    logic      wclk_q;

    assign fmt       = decode_mode(mode);
    assign in_smp[0] = smp_left;
    assign in_smp[1] = smp_right;

    sai_sample_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .valid  (smp_valid),
        .in_smp (in_smp),
        .in_err ({err_right, err_left}),
        .held   (held)
    );

    sai_master_clk #(.BCLK_HALF(BCLK_HALF)) u_mclk (
        .clk  (clk),
        .rst  (rst),
        .en   (!fmt.slave),
        .bclk (m_bclk),
        .tick (m_tick)
    );

    sai_slave_track #(.SYNC_STAGES(SYNC_STAGES)) u_strk (
        .clk       (clk),
        .rst       (rst),
        .en        (fmt.slave),
        .left_high (fmt.left_high),
        .bclk_in   (bclk_in),
        .wclk_in   (wclk_in),
        .tick      (s_tick),
        .wedge     (s_wedge),
        .at_left   (s_left)
    );

    sai_slot_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .slave   (fmt.slave),
        .m_tick  (m_tick),
        .s_tick  (s_tick),
        .s_wedge (s_wedge),
        .s_left  (s_left),
        .tick    (tick),
        .chan_nx (chan_nx),
        .idx_nx  (idx_nx)
    );

    sai_bit_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt),
        .tick    (tick),
        .chan_nx (chan_nx),
        .idx_nx  (idx_nx),
        .held    (held),
        .unlock  (unlock),
        .sdata   (sdata_out),
        .wclk    (wclk_q)
    );

    assign bclk_out = fmt.slave ? 1'b0 : m_bclk;
    assign wclk_out = fmt.slave ? 1'b0 : wclk_q;

    AST_SLAVE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
        fmt.slave |-> (!bclk_out && !wclk_out)); // R6
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!fmt.slave && $changed(sdata_out)) |-> $fell(bclk_out)); // R4

endmodule

// File: tb/test_pcm_serial_formatter.sv
module test_pcm_serial_formatter;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'd4;
    logic        valid = 1'b0;
    logic [23:0] sl = '0;
    logic [23:0] sr = '0;
    logic        el = 1'b0;
    logic        er = 1'b0;
    logic        unlock = 1'b0;
    logic        bclk_in = 1'b1;
    logic        wclk_in = 1'b0;
    logic        bclk_out;
    logic        wclk_out;
    logic        sdata_out;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    pcm_serial_formatter #(.BCLK_HALF(HALF), .SYNC_STAGES(2)) i_pcm_serial_formatter (
        .clk(clk), .rst(rst), .mode(mode), .smp_valid(valid),
        .smp_left(sl), .smp_right(sr), .err_left(el), .err_right(er),
        .unlock(unlock), .bclk_in(bclk_in), .wclk_in(wclk_in),
        .bclk_out(bclk_out), .wclk_out(wclk_out), .sdata_out(sdata_out)
    );

    // mode, left, right
    localparam logic [50:0] VEC [0:9] = '{
        {3'd0, 24'h123456, 24'hFEDCBA},
        {3'd1, 24'h800001, 24'h7FFFFF},
        {3'd2, 24'hA5A5A5, 24'h5A5A5A},
        {3'd3, 24'hC0FFEE, 24'h000001},
        {3'd4, 24'h813579, 24'h2468AC},
        {3'd5, 24'hF0F00F, 24'h0F0FF0},
        {3'd6, 24'h96C3E1, 24'h3C3C3C},
        {3'd7, 24'hFFFFFF, 24'h800000},
        {3'd0, 24'h0000FF, 24'hFFFF00},
        {3'd5, 24'h000001, 24'h800000}
    };

    function automatic logic [31:0] exp_slot(input logic [2:0] m, input logic [23:0] s);
        case (m)
            3'd0:       return {16'h0, s[23:8]};
            3'd1:       return {14'h0, s[23:6]};
            3'd2:       return {12'h0, s[23:4]};
            3'd3:       return {8'h0, s};
            3'd4, 3'd6: return {s, 8'h0};
            default:    return {1'b0, s, 7'h0};
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m);
        if (m < 3'd4) return "R1";
        if (m == 3'd4 || m == 3'd6) return "R2";
        return "R3";
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed(input logic [23:0] a, input logic [23:0] b, input logic ea, input logic eb);
        @(negedge clk);
        valid = 1'b1; sl = a; sr = b; el = ea; er = eb;
        @(negedge clk);
        valid = 1'b0; el = 1'b0; er = 1'b0;
    endtask

    task automatic grab_master(input bit inject, input logic [23:0] il, input logic [23:0] ir,
                               output logic [63:0] got, output int wbad, output int ebad, output int pbad);
        int   rises, start, pos, last_t, cyc;
        logic pb, pw, pd, rw, lvl;
        bit   inj_on;
        lvl = (mode == 3'd5) ? 1'b0 : 1'b1;
        got = '0; wbad = 0; ebad = 0; pbad = 0;
        rises = 0; start = -1; cyc = 0; last_t = -1; inj_on = 0; rw = ~lvl;
        @(negedge clk);
        pb = bclk_out; pw = wclk_out; pd = sdata_out;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (inj_on) begin valid = 1'b0; inj_on = 0; end
            if ((sdata_out !== pd || wclk_out !== pw) && !(pb == 1'b1 && bclk_out == 1'b0)) ebad++;
            if (pb == 1'b0 && bclk_out == 1'b1) begin
                if (last_t >= 0 && (cyc - last_t) != 2 * HALF) pbad++;
                last_t = cyc;
                rises++;
                if (start < 0 && rises > 40 && wclk_out == lvl && rw != lvl) start = rises;
                if (start >= 0) begin
                    pos = rises - start;
                    got[63 - pos] = sdata_out;
                    if ((pos < 32) != (wclk_out == lvl)) wbad++;
                    if (inject && pos == 10) begin
                        valid = 1'b1; sl = il; sr = ir; el = 1'b0; er = 1'b0; inj_on = 1;
                    end
                    if (pos == 63) break;
                end
                rw = wclk_out;
            end
            pb = bclk_out; pw = wclk_out; pd = sdata_out;
        end
        if (inj_on) begin @(negedge clk); valid = 1'b0; end
        if (start < 0) wbad++;
    endtask

    task automatic grab_slave(input int bps, input logic lvl, output logic [63:0] got,
                              output int tail, output int pins);
        got = '0; tail = 0; pins = 0;
        wclk_in = ~lvl; bclk_in = 1'b1;
        repeat (8) @(negedge clk);
        for (int f = 0; f < 2; f++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int b = 0; b < bps; b++) begin
                    bclk_in = 1'b0;
                    if (b == 0) wclk_in = (ch == 0) ? lvl : ~lvl;
                    repeat (6) @(negedge clk);
                    bclk_in = 1'b1;
                    if (bclk_out !== 1'b0 || wclk_out !== 1'b0) pins++;
                    if (f == 1) begin
                        if (b < 32) got[63 - (ch * 32 + b)] = sdata_out;
                        else if (sdata_out !== 1'b0) tail++;
                    end
                    repeat (6) @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R4 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] got, exp;
        logic [2:0]  m;
        logic [23:0] a, b;
        int wb, eb, pb, tl, pn;

        // R11: reset state and empty hold registers
        mode = 3'd4;
        do_reset();
        @(negedge clk);
        chk(sdata_out == 1'b0 && bclk_out == 1'b0 && wclk_out == 1'b0, "R11",
            {61'h0, sdata_out, bclk_out, wclk_out}, 64'h0);
        grab_master(0, '0, '0, got, wb, eb, pb);
        chk(got == 64'h0, "R11", got, 64'h0);

        // Vector walk over every mode
        for (int v = 0; v < 10; v++) begin
            {m, a, b} = VEC[v];
            mode = m;
            do_reset();
            feed(a, b, 1'b0, 1'b0);
            exp = {exp_slot(m, a), exp_slot(m, b)};
            if (m < 3'd6) begin
                grab_master(0, '0, '0, got, wb, eb, pb);
                chk(got == exp, req_of(m), got, exp);
                chk(wb == 0, "R5", 64'(wb), 64'h0);
                chk(eb == 0 && pb == 0, "R4", {32'(eb), 32'(pb)}, 64'h0);
            end else begin
                grab_slave(32, (m == 3'd7) ? 1'b0 : 1'b1, got, tl, pn);
                chk(got == exp, req_of(m), got, exp);
                chk(pn == 0, "R6", 64'(pn), 64'h0);
            end
        end

        // R8: flagged channel keeps last clean value
        mode = 3'd4;
        do_reset();
        feed(24'h111111, 24'h222222, 1'b0, 1'b0);
        feed(24'h333333, 24'h444444, 1'b1, 1'b0);
        grab_master(0, '0, '0, got, wb, eb, pb);
        exp = {24'h111111, 8'h0, 24'h444444, 8'h0};
        chk(got == exp, "R8", got, exp);
        feed(24'h555555, 24'h666666, 1'b0, 1'b1);
        grab_master(0, '0, '0, got, wb, eb, pb);
        exp = {24'h555555, 8'h0, 24'h444444, 8'h0};
        chk(got == exp, "R8", got, exp);

        // R9: unlock mutes, release restores
        mode = 3'd3;
        do_reset();
        feed(24'hFFFFFF, 24'hABCDEF, 1'b0, 1'b0);
        unlock = 1'b1;
        grab_master(0, '0, '0, got, wb, eb, pb);
        chk(got == 64'h0, "R9", got, 64'h0);
        unlock = 1'b0;
        grab_master(0, '0, '0, got, wb, eb, pb);
        exp = {8'h0, 24'hFFFFFF, 8'h0, 24'hABCDEF};
        chk(got == exp, "R9", got, exp);

        // R10: sample strobed mid left slot
        mode = 3'd4;
        do_reset();
        feed(24'hAAAAAA, 24'h0F0F0F, 1'b0, 1'b0);
        grab_master(1, 24'h555555, 24'hF0F0F0, got, wb, eb, pb);
        exp = {24'hAAAAAA, 8'h0, 24'hF0F0F0, 8'h0};
        chk(got == exp, "R10", got, exp);

        // R7: slave at 128 bit clocks per sample, left-justified
        mode = 3'd6;
        do_reset();
        feed(24'hC3A517, 24'h7E81FF, 1'b0, 1'b0);
        grab_slave(64, 1'b1, got, tl, pn);
        exp = {exp_slot(3'd6, 24'hC3A517), exp_slot(3'd6, 24'h7E81FF)};
        chk(got == exp, "R7", got, exp);
        chk(tl == 0, "R7", 64'(tl), 64'h0);
        chk(pn == 0, "R6", 64'(pn), 64'h0);

        // R7: slave I2S at 96 bit clocks per sample
        mode = 3'd7;
        do_reset();
        feed(24'h8000FF, 24'h01FE02, 1'b0, 1'b0);
        grab_slave(48, 1'b0, got, tl, pn);
        exp = {exp_slot(3'd7, 24'h8000FF), exp_slot(3'd7, 24'h01FE02)};
        chk(got == exp, "R7", got, exp);
        chk(tl == 0, "R7", 64'(tl), 64'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule